// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits at the head of a receive path and decides, from the destination address alone, whether an incoming frame is kept. Bytes arrive one per accepted beat, with a start-of-frame flag on the first one. The block captures the six destination bytes and runs a byte-serial CRC-32 over them as they pass. After the sixth byte it classifies the destination as unicast, multicast or broadcast. It then issues a one-cycle verdict strobe. The verdict level is held until the next frame begins.

Software sets up the filter through a small byte-wide write port. The port holds the station address, a mode byte with one enable bit per frame class plus a pass-all bit, and a 64-bin multicast hash table stored as eight bytes. Frame storage and the host register decoder belong to neighbouring blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: When mode bit 4 (value 0x10, pass-all) is set, every frame is accepted whatever its destination.
- R2: A destination of six 0xFF bytes is broadcast. Without pass-all it is accepted only when mode bit 2 (value 0x04) is set. The hash table plays no part in the decision.
- R3: A destination whose first byte has bit 0 set and that is not broadcast is multicast. Without pass-all it is rejected whenever mode bit 3 (value 0x08) is clear.
- R4: With multicast enabled, the bin is bits 31..26 of the CRC register after the six destination bytes. The CRC uses the reflected polynomial 0xEDB88320 and an all-ones seed, with no final inversion. The first byte goes in first and each byte enters LSB first. The frame is accepted only when bit (bin mod 8) of hash byte (bin div 8) is set.
- R5: Without pass-all, a unicast destination (first byte bit 0 clear) is accepted only when received byte k equals station byte k for all k in 0..5.
- R6: Write map: addresses 0..5 hold station bytes 0..5 and address 6 holds the mode byte. Addresses 8..15 hold hash bytes 0..7. A write to address 7 changes nothing.
- R7: If the sixth destination byte is sampled at edge E, dec_valid is high from edge E+1 to edge E+2 and low otherwise. dec_accept carries the verdict over that same cycle.
- R8: dec_accept keeps its value until a byte with rx_sof is sampled, and that sample clears it to 0. Bytes after the sixth, and bytes with no preceding start flag, change neither output.
- R9: A start flag restarts the byte count. A frame cut short by a new start produces no strobe. Cycles with rx_valid low are skipped without effect, so the strobe timing follows the sixth sampled byte.
- R10: Synchronous reset clears both outputs and all configuration to zero. With a zero mode byte, a broadcast frame is then rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_byte | input | 8 | Receive byte |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keeps the frame, held until next start |

## Verification
The verdict is due two edges after the sixth byte is sampled. The first edge registers the final CRC and the captured bytes. The second edge registers the verdict. The bench drives on falling edges and samples on the falling edge after each byte. It checks that the strobe is low one cycle after the sixth byte and high with the expected verdict the cycle after that. It then samples once more while trailing bytes flow, to confirm the strobe has dropped and the verdict has held. The start-flag clear is checked on the falling edge right after the flagged byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    // Mode-byte bit positions (R1..R3)
    localparam int unsigned MODE_BIT_BCAST = 2;
    localparam int unsigned MODE_BIT_MCAST = 3;
    localparam int unsigned MODE_BIT_ALL   = 4;

    typedef enum logic [1:0] {
        DST_UNICAST   = 2'd0,
        DST_MULTICAST = 2'd1,
        DST_BROADCAST = 2'd2
    } dst_class_e;

    typedef struct packed {
        logic pass_all;
        logic mcast_en;
        logic bcast_en;
    } rx_mode_t;

    // One byte of reflected CRC-32, LSB of the byte first
    function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
#(
    parameter int unsigned MAC_BYTES  = 6,
    parameter int unsigned HASH_BYTES = 8,
    parameter int unsigned AW         = 4,
    parameter int unsigned MODE_ADDR  = 6,
    parameter int unsigned HASH_BASE  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [7:0]              wr_data,
    output logic [8*MAC_BYTES-1:0]  station,
    output logic [8*HASH_BYTES-1:0] hash,
    output rx_mode_t                mode
);
    logic [7:0] st_q [MAC_BYTES];
    logic [7:0] hb_q [HASH_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAC_BYTES; i++) st_q[i] <= '0;
            for (int j = 0; j < HASH_BYTES; j++) hb_q[j] <= '0;
            mode <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < MAC_BYTES; i++) begin
                if (wr_addr == AW'(i)) st_q[i] <= wr_data;
            end
            for (int j = 0; j < HASH_BYTES; j++) begin
                if (wr_addr == AW'(HASH_BASE + j)) hb_q[j] <= wr_data;
            end
            if (wr_addr == AW'(MODE_ADDR)) begin
                mode.pass_all <= wr_data[MODE_BIT_ALL];
                mode.mcast_en <= wr_data[MODE_BIT_MCAST];
                mode.bcast_en <= wr_data[MODE_BIT_BCAST];
            end
        end
    end

    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_st
        assign station[8*g +: 8] = st_q[g];
    end
    for (genvar g = 0; g < HASH_BYTES; g++) begin : g_hb
        assign hash[8*g +: 8] = hb_q[g];
    end

endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
    import rxf_pkg::*;
#(
    parameter int unsigned MAC_BYTES = 6,
    parameter int unsigned BIN_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [7:0]             in_data,
    output logic [8*MAC_BYTES-1:0] dest,
    output logic [BIN_W-1:0]       hash_bin,
    output logic                   done
);
    localparam int unsigned CW = $clog2(MAC_BYTES + 1);

    logic [CW-1:0] cnt_q;
    logic [31:0]   crc_q;
    logic [7:0]    db_q [MAC_BYTES];
    logic          start_b;
    logic          adv_b;

    assign start_b = in_valid && in_sof;
    assign adv_b   = in_valid && !in_sof && (cnt_q != '0) && (cnt_q < CW'(MAC_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            crc_q <= CRC_SEED;
            done  <= 1'b0;
            for (int k = 0; k < MAC_BYTES; k++) db_q[k] <= '0;
        end else begin
            done <= 1'b0;
            if (start_b) begin
                cnt_q <= CW'(1);
                crc_q <= crc_step_byte(CRC_SEED, in_data);
                done  <= (MAC_BYTES == 1);
                for (int k = 0; k < MAC_BYTES; k++) db_q[k] <= (k == 0) ? in_data : 8'd0;
            end else if (adv_b) begin
                cnt_q <= cnt_q + CW'(1);
                crc_q <= crc_step_byte(crc_q, in_data);
                done  <= (cnt_q == CW'(MAC_BYTES - 1));
                for (int k = 0; k < MAC_BYTES; k++) begin
                    if (cnt_q == CW'(k)) db_q[k] <= in_data;
                end
            end
        end
    end

    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_dest
        assign dest[8*g +: 8] = db_q[g];
    end
    assign hash_bin = crc_q[31 -: BIN_W];

    // R9: the byte count never runs past the address length
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAC_BYTES));

    // R8: once the address is complete, unflagged bytes leave the capture alone
    a_r8_trailing_ignored: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(MAC_BYTES)) && !start_b |=> $stable(crc_q));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int unsigned MAC_BYTES  = 6,
    parameter int unsigned HASH_BYTES = 8,
    parameter int unsigned BIN_W      = $clog2(8 * HASH_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    done,
    input  logic                    restart,
    input  logic [8*MAC_BYTES-1:0]  dest,
    input  logic [BIN_W-1:0]        hash_bin,
    input  logic [8*MAC_BYTES-1:0]  station,
    input  logic [8*HASH_BYTES-1:0] hash,
    input  rx_mode_t                mode,
    output logic                    dec_valid,
    output logic                    dec_accept
);
    dst_class_e cls;
    logic       verdict;

    always_comb begin
        if (&dest)        cls = DST_BROADCAST;
        else if (dest[0]) cls = DST_MULTICAST;
        else              cls = DST_UNICAST;
        unique case (cls)
            DST_BROADCAST: verdict = mode.bcast_en;
            DST_MULTICAST: verdict = mode.mcast_en && hash[hash_bin];
            default:       verdict = (dest == station);
        endcase
        if (mode.pass_all) verdict = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid <= done;
            if (done)         dec_accept <= verdict;
            else if (restart) dec_accept <= 1'b0;
        end
    end

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done && !restart |=> $stable(dec_accept));

    a_r1_pass_all: assert property (@(posedge clk) disable iff (rst)
        done && mode.pass_all |=> dec_valid && dec_accept);

    a_r2_bcast_off: assert property (@(posedge clk) disable iff (rst)
        done && !mode.pass_all && (&dest) && !mode.bcast_en |=> !dec_accept);

    a_r3_mcast_off: assert property (@(posedge clk) disable iff (rst)
        done && !mode.pass_all && dest[0] && !(&dest) && !mode.mcast_en |=> !dec_accept);

    a_r5_ucast_mismatch: assert property (@(posedge clk) disable iff (rst)
        done && !mode.pass_all && !dest[0] && (dest != station) |=> !dec_accept);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int unsigned MAC_BYTES  = 6,
    parameter int unsigned HASH_BYTES = 8,
    parameter int unsigned CFG_AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int unsigned BIN_W = $clog2(8 * HASH_BYTES);

    logic [8*MAC_BYTES-1:0]  station;
    logic [8*HASH_BYTES-1:0] hash;
    rx_mode_t                mode;
    logic [8*MAC_BYTES-1:0]  dest;
    logic [BIN_W-1:0]        hash_bin;
    logic                    done;

    rxf_regs #(
        .MAC_BYTES (MAC_BYTES),
        .HASH_BYTES(HASH_BYTES),
        .AW        (CFG_AW),
        .MODE_ADDR (MAC_BYTES),
        .HASH_BASE (HASH_BYTES)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .wr_addr(cfg_addr),
        .wr_data(cfg_wdata),
        .station(station),
        .hash   (hash),
        .mode   (mode)
    );

    rxf_capture #(
        .MAC_BYTES(MAC_BYTES),
        .BIN_W    (BIN_W)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .in_valid(rx_valid),
        .in_sof  (rx_sof),
        .in_data (rx_byte),
        .dest    (dest),
        .hash_bin(hash_bin),
        .done    (done)
    );

    rxf_decide #(
        .MAC_BYTES (MAC_BYTES),
        .HASH_BYTES(HASH_BYTES),
        .BIN_W     (BIN_W)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .restart   (rx_valid && rx_sof),
        .dest      (dest),
        .hash_bin  (hash_bin),
        .station   (station),
        .hash      (hash),
        .mode      (mode),
        .dec_valid (dec_valid),
        .dec_accept(dec_accept)
    );

endmodule

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       dec_valid;
    logic       dec_accept;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rx_addr_filter uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    typedef struct packed {
        logic [7:0]  mode;
        logic [47:0] dst;   // first wire byte in bits 47:40
        logic [1:0]  hsel;  // 0 table empty, 1 only the frame's bin, 2 all but it
        logic        exp;
    } vec_t;

    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 48'h021122334455, 2'd0, 1'b1},  // R5 exact match
        '{8'h00, 48'h021122334456, 2'd0, 1'b0},  // R5 last byte differs
        '{8'h00, 48'h031122334455, 2'd1, 1'b0},  // R3 group bit, mcast off
        '{8'h00, 48'hFFFFFFFFFFFF, 2'd0, 1'b0},  // R2 bcast off
        '{8'h04, 48'hFFFFFFFFFFFF, 2'd0, 1'b1},  // R2 bcast on
        '{8'h08, 48'hFFFFFFFFFFFF, 2'd1, 1'b0},  // R2 bin set, still rejected
        '{8'h10, 48'h0A0B0C0D0E0F, 2'd0, 1'b1},  // R1 foreign unicast
        '{8'h10, 48'hFFFFFFFFFFFF, 2'd0, 1'b1},  // R1 broadcast
        '{8'h10, 48'h01005E000001, 2'd0, 1'b1},  // R1 multicast, empty table
        '{8'h00, 48'h01005E000001, 2'd1, 1'b0},  // R3 bin set but mcast off
        '{8'h08, 48'h01005E000001, 2'd1, 1'b1},  // R4 bin hit
        '{8'h08, 48'h01005E000001, 2'd2, 1'b0},  // R4 every other bin set
        '{8'h08, 48'h333300000001, 2'd1, 1'b1},  // R4 second group address
        '{8'h0C, 48'h02112233445A, 2'd2, 1'b0},  // R5 mismatch, other enables on
        '{8'h04, 48'h021122334455, 2'd0, 1'b1}   // R5 match, bcast enable irrelevant
    };

    function automatic logic [7:0] wbyte(input logic [47:0] d, input int k);
        return d[47-8*k -: 8];
    endfunction

    // Bit-serial model of the reflected CRC, built from R4
    function automatic logic [5:0] ref_bin(input logic [47:0] d);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            b = wbyte(d, k);
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ b[i];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic sof);
        rx_valid = 1'b1; rx_sof = sof; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic load_hash(input logic [47:0] d, input logic [1:0] hsel);
        logic [5:0] bin;
        logic [7:0] v;
        bin = ref_bin(d);
        for (int j = 0; j < 8; j++) begin
            v = (j == int'(bin[5:3])) ? (8'd1 << bin[2:0]) : 8'd0;
            if (hsel == 2'd0) v = 8'd0;
            else if (hsel == 2'd2) v = ~v;
            cfg(4'(8 + j), v);
        end
    endtask

    // Six address bytes, optional idle gaps, then timing and verdict checks
    task automatic frame(input logic [47:0] d, input logic exp, input bit gaps, input string req);
        for (int k = 0; k < 6; k++) begin
            push(wbyte(d, k), k == 0);
            if (gaps) @(negedge clk);
        end
        if (!gaps) chk({req, " strobe early"}, {31'd0, dec_valid}, 32'd0);
        else       chk({req, " strobe idle"}, {31'd0, dec_valid}, 32'd1);
        if (!gaps) begin
            push(8'hA5, 1'b0);
            chk({req, " strobe due"}, {31'd0, dec_valid}, 32'd1);
        end
        chk({req, " verdict"}, {31'd0, dec_accept}, {31'd0, exp});
        push(8'h5A, 1'b0);
        chk({req, " strobe single"}, {31'd0, dec_valid}, 32'd0);
        chk({req, " verdict held"}, {31'd0, dec_accept}, {31'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 valid after reset", {31'd0, dec_valid}, 32'd0);
        chk("R10 accept after reset", {31'd0, dec_accept}, 32'd0);
        frame(48'hFFFFFFFFFFFF, 1'b0, 0, "R10 zero mode rejects bcast");

        for (int k = 0; k < 6; k++) cfg(4'(k), wbyte(STATION, k));

        for (int n = 0; n < NV; n++) begin
            cfg(4'd6, VEC[n].mode);
            load_hash(VEC[n].dst, VEC[n].hsel);
            frame(VEC[n].dst, VEC[n].exp, 0, $sformatf("R1-5 vec%0d", n));
        end

        // R6: address 7 is unmapped
        cfg(4'd6, 8'h00);
        cfg(4'd7, 8'hFF);
        frame(48'hFFFFFFFFFFFF, 1'b0, 0, "R6 addr7 no effect");

        // R7/R9: idle gaps between bytes
        frame(STATION, 1'b1, 1, "R9 gapped frame");

        // R8: start flag clears a held accept
        push(8'h00, 1'b1);
        chk("R8 sof clears accept", {31'd0, dec_accept}, 32'd0);
        chk("R8 no strobe on sof", {31'd0, dec_valid}, 32'd0);

        // R9: truncated frame then full one
        push(8'h02, 1'b1);
        push(8'h11, 1'b0);
        chk("R9 short no strobe", {31'd0, dec_valid}, 32'd0);
        frame(STATION, 1'b1, 0, "R9 restart");

        // R10: reset clears held verdict
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 accept cleared", {31'd0, dec_accept}, 32'd0);
        frame(STATION, 1'b0, 0, "R10 station cleared");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule